// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge Interrupts

The port gives a processor sixteen general-purpose lines through a small word-wide register window. Each line is either an input or an output, chosen by its own direction bit. Output lines drive a latched value. Input lines pass through a synchroniser and can raise a shared interrupt on a rising or falling transition, chosen line by line. Software finds the lines that fired in a status register and clears them by writing ones there.

Bus access is a plain synchronous request: one cycle with `req` high performs a read or a write at `addr`. A read returns its data registered, with `rvalid` high in the following cycle. The port never stalls the bus, so it needs no ready signal.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the registers read as follows: direction (offset 0x08) 0xFFFF, interrupt mask (0x10) 0xFFFF, pin-control (0x18) 0xFFFF, and data output (0x04), edge select (0x0C) and interrupt status (0x14) all 0. `irq`, `pin_oe` and `pin_out` are 0.
- R2: A direction bit of 1 makes its line an input. `pin_oe[i]` is the inverse of direction bit i. `pin_out[i]` carries the stored output bit only while the line is an output, and is 0 otherwise.
- R3: A write to the data-output register (0x04) stores all sixteen bits but changes only the pins of output lines. When a line is switched from input to output, its pin shows the stored bit in the cycle after the direction write.
- R4: With edge-select bit 1, a 0-to-1 transition on an input line sets that line's status bit and raises `irq`. With edge-select bit 0, a 1-to-0 transition does the same. `irq` is high by the third rising clock edge after the pin changes.
- R5: No status bit is set for a line whose mask bit is 1 or whose direction bit is 0. A transition in the direction opposite to the selected edge also sets no status bit.
- R6: Writing to the status register (0x14) clears each bit written as 1. `irq` is high exactly when some status bit is set. An event in the same cycle as a clear of its bit leaves the bit set.
- R7: A read of the data-input register (0x00) returns the synchronised pin levels ANDed with the pin-control register (0x18).
- R8: Writes to 0x00 change no register and no pin. Reads of unmapped offsets return 0, and bits 31:16 of every read are 0.
- R9: A read request is answered in the next cycle with `rvalid` high for one cycle. Writes produce no `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response strobe |
| pin_in | input | 16 | Raw input pin levels |
| pin_out | output | 16 | Output pin levels |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench runs every combination of edge select, mask and direction against both transition polarities on one line. A design that inverts the edge sense, ignores the mask, or detects edges on output lines would set the wrong status bit. Directed tests cover these cases:
- Turning a line to output after its output bit was written: a design that drives the pin only on output-register writes would leave it at 0.
- Clearing one of two pending bits: `irq` must stay high until the second bit is cleared.
- The pin-control mask on input reads.
- Writes to the input register, which a careless decoder would let clobber a neighbouring register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 8;

  typedef enum logic [REG_AW-1:0] {
    OFS_DIN    = 8'h00,
    OFS_DOUT   = 8'h04,
    OFS_DIR    = 8'h08,
    OFS_EDGE   = 8'h0C,
    OFS_MASK   = 8'h10,
    OFS_STAT   = 8'h14,
    OFS_PINCTL = 8'h18
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mask,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= lvl;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      evt[i] = (edge_sel[i] ? (lvl[i] & ~prev_q[i]) : (~lvl[i] & prev_q[i]))
               & dir[i] & ~mask[i];
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic [NLINES-1:0] sync_lvl,
  input  logic [NLINES-1:0] evt,
  output logic [NLINES-1:0] dout,
  output logic [NLINES-1:0] dir,
  output logic [NLINES-1:0] edge_sel,
  output logic [NLINES-1:0] mask,
  output logic [NLINES-1:0] status
);
  localparam logic [NLINES-1:0] ALL1 = '1;

  logic [NLINES-1:0] pinctl;
  logic [NLINES-1:0] wv;
  logic              wr;
  logic [NLINES-1:0] clr;
  logic [NLINES-1:0] rd_val;

  assign wv  = wdata[NLINES-1:0];
  assign wr  = req & we;
  assign clr = (wr && addr == OFS_STAT) ? wv : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dir      <= ALL1;
      edge_sel <= '0;
      mask     <= ALL1;
      pinctl   <= ALL1;
    end else if (wr) begin
      case (addr)
        OFS_DOUT:   dout     <= wv;
        OFS_DIR:    dir      <= wv;
        OFS_EDGE:   edge_sel <= wv;
        OFS_MASK:   mask     <= wv;
        OFS_PINCTL: pinctl   <= wv;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else status <= (status & ~clr) | evt;
  end

  always_comb begin
    case (addr)
      OFS_DIN:    rd_val = sync_lvl & pinctl;
      OFS_DOUT:   rd_val = dout;
      OFS_DIR:    rd_val = dir;
      OFS_EDGE:   rd_val = edge_sel;
      OFS_MASK:   rd_val = mask;
      OFS_STAT:   rd_val = status;
      OFS_PINCTL: rd_val = pinctl;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req & ~we;
      if (req && !we) begin
        rdata                <= '0;
        rdata[NLINES-1:0]    <= rd_val;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int NLINES      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  logic [NLINES-1:0] sync_lvl;
  logic [NLINES-1:0] edge_evt;
  logic [NLINES-1:0] dout, dir, edge_sel, mask, status;

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
  );

  gpio_edge_detect #(.W(NLINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .edge_sel(edge_sel),
    .dir(dir), .mask(mask), .evt(edge_evt)
  );

  gpio_regfile #(.NLINES(NLINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .sync_lvl(sync_lvl),
    .evt(edge_evt), .dout(dout), .dir(dir), .edge_sel(edge_sel),
    .mask(mask), .status(status)
  );

  assign pin_oe  = ~dir;
  assign pin_out = dout & ~dir;
  assign irq     = |status;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_port_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [REG_AW-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rvalid,
  input logic [NLINES-1:0] pin_out,
  input logic [NLINES-1:0] pin_oe,
  input logic              irq,
  input logic [NLINES-1:0] evt
);
  assert_out_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_irq_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && evt == '0) |=> !irq);

  assert_event_raises_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> irq);

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == OFS_STAT && (&wdata[NLINES-1:0]) && evt == '0) |=> !irq);

  assert_din_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == OFS_DIN) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);

  assert_no_spurious_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);
endmodule

bind gpio_edge_port gpio_port_checker #(.NLINES(NLINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rvalid(rvalid), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .evt(edge_evt)
);

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  localparam int N  = 16;
  localparam int LN = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  gpio_edge_port dut (.clk(clk), .rst_n(rst_n), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // bits: [5] edge select, [4] mask, [3] dir, [2] start, [1] end, [0] expected
  localparam logic [5:0] VEC [8] = '{
    6'b1_0_1_0_1_1, 6'b1_0_1_1_0_0, 6'b0_0_1_1_0_1, 6'b0_0_1_0_1_0,
    6'b1_1_1_0_1_0, 6'b0_1_1_1_0_0, 6'b1_0_0_0_1_0, 6'b0_0_0_1_0_0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    check("R9 rvalid", {31'b0, rvalid}, 32'd1);
    d = rdata;
    @(negedge clk);
    check("R9 rvalid one cycle", {31'b0, rvalid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected <50000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 pin_oe", {16'b0, pin_oe}, 0);
    check("R1 pin_out", {16'b0, pin_out}, 0);
    rdreg(8'h08, rd); check("R1 dir", rd, 32'h0000FFFF);
    rdreg(8'h10, rd); check("R1 mask", rd, 32'h0000FFFF);
    rdreg(8'h18, rd); check("R1 pinctl", rd, 32'h0000FFFF);
    rdreg(8'h04, rd); check("R1 dout", rd, 0);
    rdreg(8'h0C, rd); check("R1 edge", rd, 0);
    rdreg(8'h14, rd); check("R1 status", rd, 0);

    // R4 R5 table walk
    foreach (VEC[k]) begin
      logic [5:0] v = VEC[k];
      logic [15:0] bitm = 16'(1) << LN;
      pin_in[LN] = v[2];
      wr(8'h10, 32'hFFFF);
      wr(8'h0C, v[5] ? 32'(bitm) : 32'h0);
      wr(8'h08, v[3] ? 32'hFFFF : 32'(~bitm));
      repeat (5) @(negedge clk);
      wr(8'h14, 32'hFFFF);
      wr(8'h10, v[4] ? 32'hFFFF : 32'(~bitm));
      pin_in[LN] = v[1];
      repeat (5) @(negedge clk);
      check($sformatf("R4/R5 vec%0d irq", k), {31'b0, irq}, {31'b0, v[0]});
      rdreg(8'h14, rd);
      check($sformatf("R4/R5 vec%0d status", k), rd, v[0] ? 32'(bitm) : 32'h0);
    end
    wr(8'h10, 32'hFFFF); wr(8'h14, 32'hFFFF); wr(8'h08, 32'hFFFF); wr(8'h0C, 0);
    pin_in = '0;

    // R3 stored output bit driven on direction switch
    wr(8'h04, 32'h00A5);
    check("R3 pin_out while input", {16'b0, pin_out}, 0);
    wr(8'h08, 32'hFF0F);
    check("R2 pin_oe", {16'b0, pin_oe}, 32'h00F0);
    check("R3 pin_out after switch", {16'b0, pin_out}, 32'h00A0);
    wr(8'h04, 32'h005A);
    check("R2 pin_out only outputs", {16'b0, pin_out}, 32'h0050);
    wr(8'h08, 32'hFFFF);

    // R6 partial clear keeps irq
    wr(8'h0C, 32'h0003); wr(8'h10, 32'hFFFC);
    pin_in[1:0] = 2'b11;
    repeat (5) @(negedge clk);
    check("R6 irq both set", {31'b0, irq}, 1);
    wr(8'h14, 32'h0001);
    check("R6 irq after partial", {31'b0, irq}, 1);
    rdreg(8'h14, rd); check("R6 status partial", rd, 32'h0002);
    wr(8'h14, 32'h0002);
    check("R6 irq after full", {31'b0, irq}, 0);
    wr(8'h10, 32'hFFFF);

    // R7 pin-control gating
    pin_in = 16'h0FFF;
    repeat (4) @(negedge clk);
    wr(8'h18, 32'h00F0);
    rdreg(8'h00, rd); check("R7 din gated", rd, 32'h000000F0);
    wr(8'h18, 32'hFFFF);
    rdreg(8'h00, rd); check("R7 din open", rd, 32'h00000FFF);

    // R8 ignored writes, unmapped reads, upper bits
    wr(8'h08, 32'hFFF0); wr(8'h04, 32'h0000000C);
    wr(8'h00, 32'hFFFFFFFF);
    check("R8 pin_oe after din write", {16'b0, pin_oe}, 32'h000F);
    check("R8 pin_out after din write", {16'b0, pin_out}, 32'h000C);
    rdreg(8'h08, rd); check("R8 dir kept", rd, 32'h0000FFF0);
    rdreg(8'h00, rd); check("R8 din kept", rd, 32'h00000FFF);
    rdreg(8'h1C, rd); check("R8 unmapped 1C", rd, 0);
    rdreg(8'h40, rd); check("R8 unmapped 40", rd, 0);
    wr(8'h04, 32'hFFFFFFFF);
    rdreg(8'h04, rd); check("R8 upper bits zero", rd, 32'h0000FFFF);
    @(negedge clk);
    check("R9 no rvalid on write", {31'b0, rvalid}, 0);

    finish_run();
  end
endmodule